// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block controls one bank of 32 general-purpose pins on behalf of a processor, through a plain single-cycle register bus (address, write enable, write data, read enable, read data). Each pin has an output value, an output-driver enable and an input sampler. The output value and the driver enable are each changed through a pair of addresses, one that sets the bits written as 1 and one that clears them, so software never has to read, modify and write back a register to touch one pin.

Every pin input passes through a two-stage synchronizer. A rising or a falling transition of the synchronized level is compared against two independent per-pin enable registers, and an enabled transition latches a bit in a pending register. Software clears pending bits by writing ones to them. A single interrupt line stays high for as long as any pending bit is set.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, pinOut, pinOe and irqOut are 0, and the pending, rising-enable and falling-enable registers read 0.
- R2: A read of offset 0x00 returns the pin levels after two synchronizer flops: a level applied to pinIn before clock edge k reads back after edge k+2. Writes to 0x00 change nothing.
- R3: A write to 0x14 sets the pinOut bits where the write data is 1, a write to 0x18 clears them; other bits keep their value. The change shows on pinOut after the write's clock edge, and reads of 0x14 or 0x18 return pinOut.
- R4: A write to 0x1C sets the pinOe bits where the write data is 1, a write to 0x20 clears them; other bits are unchanged. Reads of 0x1C or 0x20 return pinOe.
- R5: Bit i of every register belongs to pin i. A 0-to-1 change of the synchronized level of pin i with rising-enable bit i set, or a 1-to-0 change with falling-enable bit i set, sets pending bit i one clock edge after the change becomes visible at offset 0x00.
- R6: A transition on a pin whose matching enable bit is 0 leaves its pending bit unchanged.
- R7: A pin with both enable bits set raises its pending bit on either transition.
- R8: Offset 0x0C reads the pending register; writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R9: When a new enabled transition and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R10: irqOut is 1 exactly while at least one pending bit is 1.
- R11: Offsets 0x28 (rising enable) and 0x2C (falling enable) are read/write registers holding the value last written.
- R12: Reads of any unmapped offset return 0, and busRdata is 0 whenever busRd is low; writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the register accessed |
| busWr | input | 1 | Write strobe for this cycle |
| busWdata | input | 32 | Write data |
| busRd | input | 1 | Read strobe for this cycle |
| busRdata | output | 32 | Read data, valid in the same cycle as busRd |
| pinIn | input | 32 | Asynchronous pin input levels |
| pinOut | output | 32 | Output value per pin |
| pinOe | output | 32 | Output driver enable per pin |
| irqOut | output | 1 | Combined interrupt, high while any pending bit is set |

## Verification
The hardest case to reach from the ports is the cycle in which an enabled transition lands on a pending bit while software writes a one to clear that same bit, because the transition reaches the detector only after the synchronizer and the previous-value flop. The stimulus tracks the pipeline position of each pin level and issues the clearing write exactly when the transition is in the detector. Random traffic mixes pin toggles with set, clear and enable writes so that transitions on disabled pins, on pins with both enables and clears of idle bits happen many times.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int OFF_INPUT    = 'h00;
  localparam int OFF_PENDING  = 'h0C;
  localparam int OFF_OUT_SET  = 'h14;
  localparam int OFF_OUT_CLR  = 'h18;
  localparam int OFF_OE_SET   = 'h1C;
  localparam int OFF_OE_CLR   = 'h20;
  localparam int OFF_RISE_EN  = 'h28;
  localparam int OFF_FALL_EN  = 'h2C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_INPUT,
    SEL_PENDING,
    SEL_OUT,
    SEL_OE,
    SEL_RISE,
    SEL_FALL
  } readSel_e;

  typedef struct packed {
    logic     outSet;
    logic     outClr;
    logic     oeSet;
    logic     oeClr;
    logic     pendClr;
    logic     riseWr;
    logic     fallWr;
    readSel_e readSel;
  } strobes_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobes_t          strobes
);

  always_comb begin
    strobes = '0;
    strobes.readSel = SEL_NONE;
    case (busAddr)
      ADDR_W'(OFF_INPUT): begin
        strobes.readSel = busRd ? SEL_INPUT : SEL_NONE;
      end
      ADDR_W'(OFF_PENDING): begin
        strobes.pendClr = busWr;
        strobes.readSel = busRd ? SEL_PENDING : SEL_NONE;
      end
      ADDR_W'(OFF_OUT_SET): begin
        strobes.outSet  = busWr;
        strobes.readSel = busRd ? SEL_OUT : SEL_NONE;
      end
      ADDR_W'(OFF_OUT_CLR): begin
        strobes.outClr  = busWr;
        strobes.readSel = busRd ? SEL_OUT : SEL_NONE;
      end
      ADDR_W'(OFF_OE_SET): begin
        strobes.oeSet   = busWr;
        strobes.readSel = busRd ? SEL_OE : SEL_NONE;
      end
      ADDR_W'(OFF_OE_CLR): begin
        strobes.oeClr   = busWr;
        strobes.readSel = busRd ? SEL_OE : SEL_NONE;
      end
      ADDR_W'(OFF_RISE_EN): begin
        strobes.riseWr  = busWr;
        strobes.readSel = busRd ? SEL_RISE : SEL_NONE;
      end
      ADDR_W'(OFF_FALL_EN): begin
        strobes.fallWr  = busWr;
        strobes.readSel = busRd ? SEL_FALL : SEL_NONE;
      end
      default: begin
        strobes.readSel = SEL_NONE;
      end
    endcase
  end

endmodule

// File: rtl/gpio_edge_datapath.sv
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strobes,
  input  logic [PIN_COUNT-1:0] busWdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] busRdata,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];
  logic [PIN_COUNT-1:0] levelNow;
  logic [PIN_COUNT-1:0] levelPrev;
  logic [PIN_COUNT-1:0] outReg;
  logic [PIN_COUNT-1:0] oeReg;
  logic [PIN_COUNT-1:0] riseEn;
  logic [PIN_COUNT-1:0] fallEn;
  logic [PIN_COUNT-1:0] pending;
  logic [PIN_COUNT-1:0] edgeHit;
  logic [PIN_COUNT-1:0] clearMask;

  // Synchronizer chain: stage 0 samples the pad, later stages follow.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[g] <= '0;
        else       syncStage[g] <= pinIn;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[g] <= '0;
        else       syncStage[g] <= syncStage[g-1];
      end
    end
  end

  assign levelNow = syncStage[LAST_STAGE];

  always_ff @(posedge clk) begin
    if (!rstN) levelPrev <= '0;
    else       levelPrev <= levelNow;
  end

  assign edgeHit   = (levelNow & ~levelPrev & riseEn) |
                     (~levelNow & levelPrev & fallEn);
  assign clearMask = strobes.pendClr ? busWdata : '0;

  // A fresh edge wins over a clear of the same bit.
  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~clearMask) | edgeHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0;
      oeReg  <= '0;
      riseEn <= '0;
      fallEn <= '0;
    end else begin
      if (strobes.outSet) outReg <= outReg | busWdata;
      if (strobes.outClr) outReg <= outReg & ~busWdata;
      if (strobes.oeSet)  oeReg  <= oeReg | busWdata;
      if (strobes.oeClr)  oeReg  <= oeReg & ~busWdata;
      if (strobes.riseWr) riseEn <= busWdata;
      if (strobes.fallWr) fallEn <= busWdata;
    end
  end

  always_comb begin
    case (strobes.readSel)
      SEL_INPUT:   busRdata = levelNow;
      SEL_PENDING: busRdata = pending;
      SEL_OUT:     busRdata = outReg;
      SEL_OE:      busRdata = oeReg;
      SEL_RISE:    busRdata = riseEn;
      SEL_FALL:    busRdata = fallEn;
      default:     busRdata = '0;
    endcase
  end

  assign pinOut = outReg;
  assign pinOe  = oeReg;
  assign irqOut = |pending;

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PIN_COUNT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic [PIN_COUNT-1:0] busWdata,
  input  logic                 busRd,
  output logic [PIN_COUNT-1:0] busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);

  strobes_t strobes;

  gpio_edge_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strobes (strobes)
  );

  gpio_edge_datapath #(
    .PIN_COUNT   (PIN_COUNT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .busRdata (busRdata),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/gpio_edge_checker.sv
module gpio_edge_checker
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PIN_COUNT = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWr,
  input logic [PIN_COUNT-1:0] busWdata,
  input logic                 busRd,
  input logic [PIN_COUNT-1:0] busRdata,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic                 irqOut
);

  logic wrOutSet, wrOutClr, wrOeSet, wrOeClr, wrPend, rdPend;
  assign wrOutSet = busWr && (busAddr == ADDR_W'(OFF_OUT_SET));
  assign wrOutClr = busWr && (busAddr == ADDR_W'(OFF_OUT_CLR));
  assign wrOeSet  = busWr && (busAddr == ADDR_W'(OFF_OE_SET));
  assign wrOeClr  = busWr && (busAddr == ADDR_W'(OFF_OE_CLR));
  assign wrPend   = busWr && (busAddr == ADDR_W'(OFF_PENDING));
  assign rdPend   = busRd && (busAddr == ADDR_W'(OFF_PENDING));

  a_r3_out_set: assert property (@(posedge clk) disable iff (!rstN)
    wrOutSet |=> pinOut == ($past(pinOut) | $past(busWdata)));

  a_r3_out_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrOutClr |=> pinOut == ($past(pinOut) & ~$past(busWdata)));

  a_r4_oe_set: assert property (@(posedge clk) disable iff (!rstN)
    wrOeSet |=> pinOe == ($past(pinOe) | $past(busWdata)));

  a_r4_oe_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrOeClr |=> pinOe == ($past(pinOe) & ~$past(busWdata)));

  a_r12_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrOutSet || wrOutClr) |=> $stable(pinOut));

  a_r12_oe_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrOeSet || wrOeClr) |=> $stable(pinOe));

  a_r8_irq_drop_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(wrPend));

  a_r10_irq_matches_read: assert property (@(posedge clk) disable iff (!rstN)
    rdPend |-> ((busRdata != '0) == irqOut));

  a_r12_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> busRdata == '0);

endmodule

bind gpio_edge_bank gpio_edge_checker #(
  .ADDR_W    (ADDR_W),
  .PIN_COUNT (PIN_COUNT)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busWdata (busWdata),
  .busRd    (busRd),
  .busRdata (busRdata),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .irqOut   (irqOut)
);

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRd = 1'b0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench-side view of the bank built from the requirements.
  logic [31:0] mS0, mS1, mPrev, mOut, mOe, mRise, mFall, mPend;

  always #4 clk = ~clk;

  gpio_edge_bank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRd(busRd), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00:        return mS1;
      8'h0C:        return mPend;
      8'h14, 8'h18: return mOut;
      8'h1C, 8'h20: return mOe;
      8'h28:        return mRise;
      8'h2C:        return mFall;
      default:      return 32'h0;
    endcase
  endfunction

  function automatic string readTag(input logic [7:0] a);
    case (a)
      8'h00:        return "R2";
      8'h0C:        return "R8";
      8'h14, 8'h18: return "R3";
      8'h1C, 8'h20: return "R4";
      8'h28, 8'h2C: return "R11";
      default:      return "R12";
    endcase
  endfunction

  function automatic logic [31:0] modelEdges();
    return (mS1 & ~mPrev & mRise) | (~mS1 & mPrev & mFall);
  endfunction

  task automatic modelReset();
    mS0 = '0; mS1 = '0; mPrev = '0; mOut = '0;
    mOe = '0; mRise = '0; mFall = '0; mPend = '0;
  endtask

  // One bus cycle: check outputs, drive, check read, advance the model.
  task automatic step(input logic [7:0] a, input logic wr, input logic [31:0] wd,
                      input logic rd, input logic [31:0] pins, input string tag);
    logic [31:0] nPend, nOut, nOe, nRise, nFall;
    @(negedge clk);
    chk("R3 pinOut", pinOut, mOut);
    chk("R4 pinOe", pinOe, mOe);
    chk("R10 irqOut", {31'b0, irqOut}, {31'b0, mPend != 0});
    busAddr = a; busWr = wr; busWdata = wd; busRd = rd; pinIn = pins;
    #1;
    if (rd) chk(tag != "" ? tag : readTag(a), busRdata, modelRead(a));
    else    chk("R12 idle read", busRdata, 32'h0);
    nPend = (mPend & ~((wr && a == 8'h0C) ? wd : 32'h0)) | modelEdges();
    nOut = mOut; nOe = mOe; nRise = mRise; nFall = mFall;
    if (wr) begin
      case (a)
        8'h14: nOut = mOut | wd;
        8'h18: nOut = mOut & ~wd;
        8'h1C: nOe = mOe | wd;
        8'h20: nOe = mOe & ~wd;
        8'h28: nRise = wd;
        8'h2C: nFall = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    mPrev = mS1; mS1 = mS0; mS0 = pins;
    mPend = nPend; mOut = nOut; mOe = nOe; mRise = nRise; mFall = nFall;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(8'h00, 1'b0, 32'h0, 1'b0, pinIn, "");
  endtask

  task automatic rdReg(input logic [7:0] a, input string tag);
    step(a, 1'b0, 32'h0, 1'b1, pinIn, tag);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    step(a, 1'b1, d, 1'b0, pinIn, "");
  endtask

  task automatic setPins(input logic [31:0] p);
    step(8'h00, 1'b0, 32'h0, 1'b0, p, "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrList [10];
    logic [31:0] pins;
    addrList = '{8'h00, 8'h0C, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h28, 8'h2C, 8'h04, 8'h30};
    void'($urandom(32'd1234));
    modelReset();
    pinIn = 32'hFFFF_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values at the ports
    chk("R1 pinOut", pinOut, 32'h0);
    chk("R1 pinOe", pinOe, 32'h0);
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);
    rstN = 1'b1;
    pinIn = '0;
    rdReg(8'h0C, "R1 pending");
    rdReg(8'h28, "R1 rise enable");
    rdReg(8'h2C, "R1 fall enable");
    idle(3);

    // R2: two-flop latency on input read
    setPins(32'h0000_00A5);
    rdReg(8'h00, "R2 after one edge");
    chk("R2 not yet visible", busRdata, 32'h0);
    rdReg(8'h00, "R2 after two edges");
    chk("R2 visible", busRdata, 32'h0000_00A5);
    wrReg(8'h00, 32'hFFFF_FFFF);
    rdReg(8'h00, "R2 write ignored");

    // R3 / R4: set and clear masks
    wrReg(8'h14, 32'h0000_F00F);
    wrReg(8'h18, 32'h0000_000C);
    rdReg(8'h18, "R3 out read");
    chk("R3 value", busRdata, 32'h0000_F003);
    wrReg(8'h1C, 32'h8000_0001);
    wrReg(8'h20, 32'h0000_0001);
    rdReg(8'h1C, "R4 oe read");
    chk("R4 value", busRdata, 32'h8000_0000);

    // R5 / R6 / R7: edge selection
    setPins(32'h0);
    idle(4);
    wrReg(8'h28, 32'h0000_0208);
    wrReg(8'h2C, 32'h0000_0220);
    setPins(32'h0000_02A8);
    idle(4);
    rdReg(8'h0C, "R5 rising");
    chk("R5 R6 R7 rising set", busRdata, 32'h0000_0208);
    wrReg(8'h0C, 32'h0000_0000);
    rdReg(8'h0C, "R8 zero write");
    wrReg(8'h0C, 32'h0000_0208);
    setPins(32'h0);
    idle(4);
    rdReg(8'h0C, "R5 falling");
    chk("R5 R6 R7 falling set", busRdata, 32'h0000_0220);
    wrReg(8'h0C, 32'hFFFF_FFFF);
    idle(1);
    rdReg(8'h0C, "R8 cleared");
    chk("R10 irq low", {31'b0, irqOut}, 32'h0);

    // R9: clear and new edge on the same bit in the same cycle
    wrReg(8'h28, 32'h0000_0001);
    wrReg(8'h2C, 32'h0);
    setPins(32'h0000_0001);
    while (!modelEdges()[0]) idle(1);
    wrReg(8'h0C, 32'h0000_0001);
    rdReg(8'h0C, "R9 collision");
    chk("R9 bit kept", busRdata & 32'h1, 32'h1);
    wrReg(8'h0C, 32'hFFFF_FFFF);

    // R12: unmapped offsets
    wrReg(8'h30, 32'hFFFF_FFFF);
    rdReg(8'h30, "R12 unmapped");
    rdReg(8'h04, "R12 unmapped 04");

    // Random traffic
    pins = pinIn;
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic wr, rd;
      logic [31:0] wd;
      a  = addrList[$urandom_range(0, 9)];
      wr = ($urandom_range(0, 2) == 0);
      if (a == 8'h0C && $urandom_range(0, 3) != 0) wr = 1'b0;
      rd = ($urandom_range(0, 1) == 0);
      wd = $urandom();
      if ($urandom_range(0, 3) == 0) pins = pins ^ ($urandom() & $urandom());
      step(a, wr, wd, rd, pins, "");
    end
    idle(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule